// File: doc/BRIEF.md
# Boot Chip-Select Decoder with Wait-State Acknowledge

This block turns the processor's address and active-low address strobe into a small set of active-low chip-select strobes. Each strobe has a programmable address window made of a base and a compare mask, an enable bit, and a wait-state count from 0 to 7. For every bus cycle the block picks at most one window. It drives that strobe low for the whole cycle. It then asserts an active-low data acknowledge once the programmed number of clocks has elapsed.

Select 0 is the boot select. It is live straight out of reset with six wait states and matches every address outside a fixed internal register window, so instruction fetches work before any software setup. Software can later shrink or move it and change its wait count. Every select pin can instead be configured as a general-purpose pin with its own output value and output enable. The last pin comes out of reset as a general-purpose input. Configuration writes arriving during a bus cycle are held back and applied once the strobe is released.

Top module: `boot_cs_unit`

## Requirements
- R1: After reset, only select 0 is enabled. Pins 0 to N-2 are in select mode and drive high with output enable 1. Pin N-1 is a general-purpose input with output enable 0. The acknowledge is high.
- R2: Out of reset, select 0 matches every address outside the internal window and acknowledges after 6 clocks.
- R3: An address inside the internal window (address AND INT_MASK equals INT_BASE AND INT_MASK; by default 0xFFF000 to 0xFFFFFF) asserts no strobe and no acknowledge, whatever the windows hold.
- R4: Select i matches when (address AND mask_i) equals (base_i AND mask_i), its enable is 1 and it is in select mode. A mask bit of 1 means that bit is compared.
- R5: Call edge 0 the first rising clock edge that samples the address strobe low. The acknowledge goes low after edge W, where W is the winner's wait count (0 to 7), and not before.
- R6: The chosen strobe stays low, and the acknowledge stays low once asserted, until the address strobe rises. Both return high as soon as it does.
- R7: When windows overlap, the lowest-numbered select wins. At most one strobe is low at a time.
- R8: A configuration write made while the address strobe is low changes nothing in the current cycle. It takes effect at the first clock edge that samples the address strobe high.
- R9: In general-purpose mode a pin drives its output value, with output enable equal to its direction bit, and never carries a strobe. Its input reaches gpio_in_o after two clock edges.
- R10: An address that matches no enabled window produces no strobe and no acknowledge.
- R11: Select 0 can be reprogrammed to a new window and wait count. It then stops matching addresses outside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | Bus address |
| as_ni | input | 1 | Active-low address strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Select entry being written |
| cfg_base_i | input | 24 | Window base |
| cfg_mask_i | input | 24 | Window compare mask |
| cfg_ws_i | input | 3 | Wait-state count |
| cfg_en_i | input | 1 | Window enable |
| cfg_gpio_i | input | 1 | 1 = general-purpose pin, 0 = select |
| cfg_dir_i | input | 1 | General-purpose output enable |
| cfg_dout_i | input | 1 | General-purpose output value |
| pin_i | input | N_CS | Pin input levels |
| pin_o | output | N_CS | Pin output levels |
| pin_oe_o | output | N_CS | Pin output enables |
| gpio_in_o | output | N_CS | Synchronised pin inputs |
| dtack_no | output | 1 | Active-low data acknowledge |

## Verification
The configuration path and the decode path can act in the same cycle. This happens when a write to the select that is serving the current bus cycle arrives while the strobe is still low. The bench starts a cycle on select 1 and disables select 1 in the clock after the decision edge. It then checks that the strobe and the acknowledge timing of that cycle are unchanged. The next cycle to the same address must be served by the overlapping higher-numbered select with its own wait count, which shows that the write was held and then applied between cycles.

// File: rtl/csu_pkg.sv
package csu_pkg;
  parameter int unsigned AW  = 24;
  parameter int unsigned WSW = 3;

  typedef logic [AW-1:0] addr_t;

  typedef struct packed {
    addr_t          base;
    addr_t          mask;
    logic [WSW-1:0] ws;
    logic           en;
    logic           gpio;
    logic           dir;
    logic           dout;
  } cs_cfg_t;

  localparam logic [WSW-1:0] BOOT_WS = WSW'(6);
endpackage

// File: rtl/csu_cfg.sv
module csu_cfg
  import csu_pkg::*;
#(
  parameter int unsigned N_CS  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_idle_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  cs_cfg_t          wdata_i,
  output cs_cfg_t          cfg_o [N_CS]
);

  cs_cfg_t          cfg_q [N_CS];
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  cs_cfg_t          pend_data_q;

  function automatic cs_cfg_t reset_entry(input int unsigned i);
    cs_cfg_t e;
    e = '0;
    if (i == 0) begin
      e.en = 1'b1;
      e.ws = BOOT_WS;
    end else if (i == N_CS - 1) begin
      e.gpio = 1'b1;
    end
    return e;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CS; i++) cfg_q[i] <= reset_entry(i);
      pend_q      <= 1'b0;
      pend_idx_q  <= '0;
      pend_data_q <= '0;
    end else if (we_i) begin
      if (bus_idle_i) begin
        if (32'(idx_i) < N_CS) cfg_q[idx_i] <= wdata_i;
        pend_q <= 1'b0;
      end else begin
        // held until the strobe is released
        pend_q      <= 1'b1;
        pend_idx_q  <= idx_i;
        pend_data_q <= wdata_i;
      end
    end else if (pend_q && bus_idle_i) begin
      if (32'(pend_idx_q) < N_CS) cfg_q[pend_idx_q] <= pend_data_q;
      pend_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_CS; g++) begin : g_out
    assign cfg_o[g] = cfg_q[g];

    // R8: no window changes while a bus cycle is in progress
    a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_idle_i |=> $stable(cfg_q[g]));
  end

endmodule

// File: rtl/csu_decode.sv
module csu_decode
  import csu_pkg::*;
#(
  parameter int unsigned N_CS     = 4,
  parameter int unsigned IDX_W    = 2,
  parameter addr_t       INT_BASE = 24'hFFF000,
  parameter addr_t       INT_MASK = 24'hFFF000
) (
  input  addr_t                   addr_i,
  input  logic [N_CS-1:0][AW-1:0] base_i,
  input  logic [N_CS-1:0][AW-1:0] mask_i,
  input  logic [N_CS-1:0]         en_i,
  input  logic [N_CS-1:0]         gpio_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    int_o
);

  logic [N_CS-1:0] match;

  for (genvar g = 0; g < N_CS; g++) begin : g_match
    assign match[g] = en_i[g] & ~gpio_i[g] &
                      ((addr_i & mask_i[g]) == (base_i[g] & mask_i[g]));
  end

  assign int_o = (addr_i & INT_MASK) == (INT_BASE & INT_MASK);

  // lowest index wins: scan downward so the last hit kept is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = N_CS - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = (|match) & ~int_o;

endmodule

// File: rtl/csu_wait.sv
module csu_wait
  import csu_pkg::*;
#(
  parameter int unsigned N_CS  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     active_i,
  input  logic [IDX_W-1:0]         win_idx_i,
  input  logic [N_CS-1:0][WSW-1:0] ws_i,
  input  logic [IDX_W-1:0]         sel_idx_i,
  output logic                     done_o
);

  logic [N_CS-1:0][WSW-1:0] cnt_q;

  for (genvar g = 0; g < N_CS; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (start_i && win_idx_i == IDX_W'(g)) begin
        cnt_q[g] <= ws_i[g];
      end else if (active_i && cnt_q[g] != '0) begin
        cnt_q[g] <= cnt_q[g] - WSW'(1);
      end
    end

    // R5: one wait state consumed per clock while the cycle runs
    a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && !start_i && cnt_q[g] != '0) |=> cnt_q[g] == $past(cnt_q[g]) - WSW'(1));
  end

  always_comb begin
    done_o = 1'b0;
    for (int i = 0; i < N_CS; i++) begin
      if (sel_idx_i == IDX_W'(i)) done_o = (cnt_q[i] == '0);
    end
  end

endmodule

// File: rtl/csu_pin.sv
module csu_pin #(
  parameter int unsigned N_CS = 4,
  parameter int unsigned SYNC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CS-1:0] cs_n_i,
  input  logic [N_CS-1:0] gpio_i,
  input  logic [N_CS-1:0] dir_i,
  input  logic [N_CS-1:0] dout_i,
  input  logic [N_CS-1:0] pin_i,
  output logic [N_CS-1:0] pin_o,
  output logic [N_CS-1:0] pin_oe_o,
  output logic [N_CS-1:0] gpio_in_o
);

  for (genvar g = 0; g < N_CS; g++) begin : g_pin
    logic [SYNC-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC-2:0], pin_i[g]};
    end

    assign gpio_in_o[g] = sync_q[SYNC-1];
    assign pin_o[g]     = gpio_i[g] ? dout_i[g] : cs_n_i[g];
    assign pin_oe_o[g]  = gpio_i[g] ? dir_i[g]  : 1'b1;
  end

endmodule

// File: rtl/boot_cs_unit.sv
module boot_cs_unit
  import csu_pkg::*;
#(
  parameter int unsigned N_CS        = 4,
  parameter addr_t       INT_BASE    = 24'hFFF000,
  parameter addr_t       INT_MASK    = 24'hFFF000,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             as_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [AW-1:0]    cfg_base_i,
  input  logic [AW-1:0]    cfg_mask_i,
  input  logic [WSW-1:0]   cfg_ws_i,
  input  logic             cfg_en_i,
  input  logic             cfg_gpio_i,
  input  logic             cfg_dir_i,
  input  logic             cfg_dout_i,
  input  logic [N_CS-1:0]  pin_i,
  output logic [N_CS-1:0]  pin_o,
  output logic [N_CS-1:0]  pin_oe_o,
  output logic [N_CS-1:0]  gpio_in_o,
  output logic             dtack_no
);

  cs_cfg_t                  wdata;
  cs_cfg_t                  cfg [N_CS];
  logic [N_CS-1:0][AW-1:0]  base_v, mask_v;
  logic [N_CS-1:0][WSW-1:0] ws_v;
  logic [N_CS-1:0]          en_v, gpio_v, dir_v, dout_v;

  logic             dec_hit, dec_int;
  logic [IDX_W-1:0] dec_idx;
  logic             active_q, hit_q, int_q;
  logic [IDX_W-1:0] idx_q;
  logic             start, sel_live, wait_done;
  logic [N_CS-1:0]  cs_n;

  assign wdata = '{base: cfg_base_i, mask: cfg_mask_i, ws: cfg_ws_i,
                   en: cfg_en_i, gpio: cfg_gpio_i, dir: cfg_dir_i,
                   dout: cfg_dout_i};

  csu_cfg #(.N_CS(N_CS), .IDX_W(IDX_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_idle_i (as_ni),
    .we_i       (cfg_we_i),
    .idx_i      (cfg_idx_i),
    .wdata_i    (wdata),
    .cfg_o      (cfg)
  );

  for (genvar g = 0; g < N_CS; g++) begin : g_split
    assign base_v[g] = cfg[g].base;
    assign mask_v[g] = cfg[g].mask;
    assign ws_v[g]   = cfg[g].ws;
    assign en_v[g]   = cfg[g].en;
    assign gpio_v[g] = cfg[g].gpio;
    assign dir_v[g]  = cfg[g].dir;
    assign dout_v[g] = cfg[g].dout;
  end

  csu_decode #(
    .N_CS(N_CS), .IDX_W(IDX_W), .INT_BASE(INT_BASE), .INT_MASK(INT_MASK)
  ) u_decode (
    .addr_i (addr_i),
    .base_i (base_v),
    .mask_i (mask_v),
    .en_i   (en_v),
    .gpio_i (gpio_v),
    .hit_o  (dec_hit),
    .idx_o  (dec_idx),
    .int_o  (dec_int)
  );

  assign start = ~as_ni & ~active_q;

  // window choice frozen at the first edge of the cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hit_q    <= 1'b0;
      int_q    <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= ~as_ni;
      if (start) begin
        hit_q <= dec_hit;
        int_q <= dec_int;
        idx_q <= dec_idx;
      end
    end
  end

  csu_wait #(.N_CS(N_CS), .IDX_W(IDX_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .active_i  (active_q),
    .win_idx_i (dec_idx),
    .ws_i      (ws_v),
    .sel_idx_i (idx_q),
    .done_o    (wait_done)
  );

  assign sel_live = active_q & hit_q & ~as_ni;

  always_comb begin
    cs_n = '1;
    for (int i = 0; i < N_CS; i++) begin
      if (idx_q == IDX_W'(i)) cs_n[i] = ~sel_live;
    end
  end

  assign dtack_no = ~(sel_live & wait_done);

  csu_pin #(.N_CS(N_CS), .SYNC(SYNC_STAGES)) u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_n),
    .gpio_i    (gpio_v),
    .dir_i     (dir_v),
    .dout_i    (dout_v),
    .pin_i     (pin_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .gpio_in_o (gpio_in_o)
  );

  // R7: never more than one strobe
  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n));

  // R10: acknowledge only alongside a driven strobe
  a_r10_ack_with_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> (cs_n != '1));

  // R3: internal register window stays silent
  a_r3_int_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && int_q) |-> ((&cs_n) && dtack_no));

  // R6: acknowledge held until the strobe is released
  a_r6_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ni && !dtack_no) |=> (as_ni || !dtack_no));

endmodule

// File: tb/boot_cs_unit_bench.sv
module boot_cs_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        as_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [23:0] cfg_base = '0, cfg_mask = '0;
  logic [2:0]  cfg_ws = '0;
  logic        cfg_en = 1'b0, cfg_gpio = 1'b0, cfg_dir = 1'b0, cfg_dout = 1'b0;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_out, pin_oe, gpio_in;
  logic        dtack_n;

  int n_chk = 0;
  int n_err = 0;
  logic [3:0] selm = 4'b0111; // pins currently in select mode

  always #4 clk = ~clk;

  boot_cs_unit u_boot_cs_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .as_ni(as_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base),
    .cfg_mask_i(cfg_mask), .cfg_ws_i(cfg_ws), .cfg_en_i(cfg_en),
    .cfg_gpio_i(cfg_gpio), .cfg_dir_i(cfg_dir), .cfg_dout_i(cfg_dout),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .gpio_in_o(gpio_in), .dtack_no(dtack_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [23:0] b, input logic [23:0] m,
                           input int ws, input bit en, input bit gp,
                           input bit dr, input bit dv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_base = b; cfg_mask = m;
    cfg_ws = 3'(ws); cfg_en = en; cfg_gpio = gp; cfg_dir = dr; cfg_dout = dv;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one bus cycle; idx < 0 means no strobe expected
  task automatic bus(input logic [23:0] a, input int idx, input int ws, input string rq);
    logic [3:0] exp_cs;
    int last;
    exp_cs = 4'hF;
    if (idx >= 0) exp_cs[idx] = 1'b0;
    last = (idx >= 0) ? ws + 1 : 4;
    @(negedge clk);
    addr = a; as_n = 1'b0;
    for (int j = 0; j <= last; j++) begin
      @(negedge clk);
      chk((pin_out & selm) == (exp_cs & selm), rq, "strobe", pin_out, exp_cs);
      chk(dtack_n == !((idx >= 0) && (j >= ws)), rq, "ack", dtack_n,
          !((idx >= 0) && (j >= ws)));
    end
    as_n = 1'b1;
    #1;
    chk((pin_out & selm) == selm, "R6", "strobe release", pin_out, selm);
    chk(dtack_n == 1'b1, "R6", "ack release", dtack_n, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk((pin_out & 4'b0111) == 4'b0111, "R1", "pins idle", pin_out, 4'b0111);
    chk(pin_oe == 4'b0111, "R1", "output enables", pin_oe, 4'b0111);
    chk(dtack_n == 1'b1, "R1", "ack idle", dtack_n, 1);
  endtask

  task automatic t_boot;
    bus(24'h001234, 0, 6, "R2");
    bus(24'hFFEFFF, 0, 6, "R2");
    bus(24'hFFF000, -1, 0, "R3");
    bus(24'hFFFFFF, -1, 0, "R3");
  endtask

  task automatic t_retarget;
    cfg_write(0, 24'h000000, 24'hF00000, 2, 1, 0, 0, 0);
    bus(24'h0ABCDE, 0, 2, "R11");
    bus(24'h100000, -1, 0, "R10");
  endtask

  task automatic t_match;
    cfg_write(1, 24'h100000, 24'hF00000, 0, 1, 0, 0, 0);
    bus(24'h1FFFFF, 1, 0, "R5");
    cfg_write(1, 24'h100000, 24'hF00000, 7, 1, 0, 0, 0);
    bus(24'h100010, 1, 7, "R5");
    cfg_write(1, 24'h130000, 24'hFF0000, 1, 1, 0, 0, 0);
    bus(24'h13ABCD, 1, 1, "R4");
    bus(24'h140000, -1, 0, "R4");
  endtask

  task automatic t_prio;
    cfg_write(2, 24'h100000, 24'hF00000, 3, 1, 0, 0, 0);
    bus(24'h13ABCD, 1, 1, "R7");
    bus(24'h150000, 2, 3, "R7");
  endtask

  task automatic t_defer;
    @(negedge clk);
    addr = 24'h130000; as_n = 1'b0;
    @(negedge clk);
    chk(pin_out[1] == 1'b0 && pin_out[2] == 1'b1, "R8", "strobe j0", pin_out, 4'b1101);
    chk(dtack_n == 1'b1, "R8", "ack j0", dtack_n, 1);
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_base = 24'h130000; cfg_mask = 24'hFF0000;
    cfg_ws = 3'd1; cfg_en = 1'b0; cfg_gpio = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      chk(pin_out[1] == 1'b0, "R8", "strobe held", pin_out, 4'b1101);
      chk(dtack_n == 1'b0, "R8", "ack held", dtack_n, 0);
      @(negedge clk);
    end
    as_n = 1'b1;
    @(negedge clk);
    bus(24'h130000, 2, 3, "R8");
  endtask

  task automatic t_gpio;
    cfg_write(3, 24'h0, 24'h0, 0, 0, 1, 1, 0);
    #1;
    chk(pin_oe[3] == 1'b1, "R9", "oe", pin_oe, 4'b1111);
    chk(pin_out[3] == 1'b0, "R9", "dout 0", pin_out[3], 0);
    cfg_write(3, 24'h0, 24'h0, 0, 0, 1, 1, 1);
    #1;
    chk(pin_out[3] == 1'b1, "R9", "dout 1", pin_out[3], 1);
    pin_in[3] = 1'b1;
    @(negedge clk);
    chk(gpio_in[3] == 1'b0, "R9", "sync stage 1", gpio_in, 0);
    @(negedge clk);
    chk(gpio_in[3] == 1'b1, "R9", "sync stage 2", gpio_in, 4'b1000);
    cfg_write(2, 24'h200000, 24'hF00000, 0, 1, 1, 1, 1);
    selm = 4'b0011;
    bus(24'h200000, -1, 0, "R9");
    chk(pin_out[2] == 1'b1 && pin_oe[2] == 1'b1, "R9", "gpio pin no strobe",
        {pin_oe[2], pin_out[2]}, 2'b11);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot();
    t_retarget();
    t_match();
    t_prio();
    t_defer();
    t_gpio();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

endmodule